// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point words that have a sign bit, an 8-bit exponent stored with a bias of 127, and a 23-bit fraction behind an implied leading one. It adds the exponents and removes one bias. It restores the hidden one on both significands and forms their 48-bit product. It shifts that product at most one place to normalize it, rounds to nearest with ties to even, and shifts once more if the rounding carries out. The result sign is the exclusive OR of the two input signs.

Zero, infinity and NaN inputs are detected from their codes and handled before the normal path. Any input with an exponent field of zero counts as zero, so subnormal inputs are flushed. Results that are out of range are clamped to signed infinity or signed zero, and a flag reports each case. The product and the three flags are registered, so they appear one clock after the operands are presented.

Top module: `fp32_mul`

## Requirements
- R1: For two normal inputs whose result stays in range, the output exponent field equals ea + eb - 127, plus the normalization and rounding adjustments, and the fraction field holds the rounded product fraction (for example 0x40000000 x 0x40400000 = 0x40C00000).
- R2: Bit 31 of every non-NaN result equals the XOR of bit 31 of the two inputs.
- R3: When the final exponent exceeds 254, the output is signed infinity (exponent 0xFF, fraction 0) and the overflow flag is 1.
- R4: When the final exponent is below 1, the output is signed zero (bits 30:0 all zero) and the underflow flag is 1.
- R5: If either input is NaN (exponent 0xFF, fraction not zero), or one input is zero and the other is infinity, the output is 0x7FC00000 and the invalid flag is 1.
- R6: Infinity times a nonzero non-NaN input gives signed infinity, and zero times a non-infinite non-NaN input gives signed zero, with all flags 0. An input with exponent field 0 is treated as zero whatever its fraction.
- R7: When the significand product is 2 or more (product bit 47 set), it is shifted right by one place and the exponent is incremented.
- R8: Rounding is to nearest. The guard bit is the first bit below the kept 24 bits, and the sticky bit is the OR of all bits below the guard bit. A value exactly halfway rounds to an even last bit.
- R9: When rounding carries out of the 24-bit significand, the result is renormalized: the fraction becomes 0 and the exponent goes up by one. This second increment can also cause overflow.
- R10: The outputs are registered with one cycle of latency. While rst_n is low, the product and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears the output registers |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| product | output | 32 | Registered result |
| overflow | output | 1 | Result was clamped to infinity |
| underflow | output | 1 | Result was clamped to zero |
| invalid | output | 1 | Result is the canonical quiet NaN |

## Verification
All internal state sits in one register stage. A wrong exponent sum, normalize choice or rounding decision therefore appears at the port one cycle after the operands are presented, as a result off by a factor of two or off by one unit in the last place. The test vectors separate the cases that are hard to tell apart: ties that round down, ties that round up, values just above the halfway point, a product that rounds up to 2.0, and exponents right at the edges of the range. A wrong order of the special-case checks shows up directly as a wrong flag or a wrong sign on zero or infinity.

// File: rtl/fp32_mul_pkg.sv
package fp32_mul_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int XEXP_W = EXP_W + 2;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_MAX = (1 << EXP_W) - 2;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NORM = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } num_class_e;

  function automatic num_class_e classify(input logic [EXP_W-1:0] e,
                                          input logic [FRAC_W-1:0] f);
    if (e == '0)       return CLS_ZERO;
    else if (&e)       return (f == '0) ? CLS_INF : CLS_NAN;
    else               return CLS_NORM;
  endfunction

  function automatic logic [XEXP_W-1:0] exp_combine(input logic [EXP_W-1:0] ea,
                                                    input logic [EXP_W-1:0] eb,
                                                    input logic norm,
                                                    input logic carry);
    return XEXP_W'(ea) + XEXP_W'(eb) + XEXP_W'(norm) + XEXP_W'(carry)
           - XEXP_W'(BIAS);
  endfunction

  function automatic logic rne_up(input logic lsb, input logic guard,
                                  input logic sticky);
    return guard & (sticky | lsb);
  endfunction

  function automatic logic [WORD_W-1:0] qnan_word();
    return {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  endfunction
endpackage

// File: rtl/fp32_mul_unpack.sv
module fp32_mul_unpack
  import fp32_mul_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic              sign_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic [SIG_W-1:0]  sig_o,
  output num_class_e        cls_o
);
  logic [FRAC_W-1:0] frac;

  assign sign_o = word_i[WORD_W-1];
  assign exp_o  = word_i[WORD_W-2 -: EXP_W];
  assign frac   = word_i[FRAC_W-1:0];
  assign sig_o  = {1'b1, frac};
  assign cls_o  = classify(exp_o, frac);
endmodule

// File: rtl/fp32_mul_core.sv
module fp32_mul_core
  import fp32_mul_pkg::*;
(
  input  logic [SIG_W-1:0]  sig_a_i,
  input  logic [SIG_W-1:0]  sig_b_i,
  input  logic [EXP_W-1:0]  exp_a_i,
  input  logic [EXP_W-1:0]  exp_b_i,
  output logic [FRAC_W-1:0] frac_o,
  output logic [XEXP_W-1:0] exp_o,
  output logic              norm_shift_o,
  output logic              round_up_o,
  output logic              round_carry_o
);
  logic [PROD_W-1:0] prod;
  logic [SIG_W-1:0]  kept;
  logic              guard_bit;
  logic              sticky_bit;
  logic [SIG_W:0]    rsum;

  assign prod         = PROD_W'(sig_a_i) * PROD_W'(sig_b_i);
  assign norm_shift_o = prod[PROD_W-1];

  always_comb begin
    if (norm_shift_o) begin
      kept       = prod[PROD_W-1 -: SIG_W];
      guard_bit  = prod[PROD_W-1-SIG_W];
      sticky_bit = |prod[PROD_W-2-SIG_W:0];
    end else begin
      kept       = prod[PROD_W-2 -: SIG_W];
      guard_bit  = prod[PROD_W-2-SIG_W];
      sticky_bit = |prod[PROD_W-3-SIG_W:0];
    end
  end

  assign round_up_o    = rne_up(kept[0], guard_bit, sticky_bit);
  assign rsum          = {1'b0, kept} + (SIG_W+1)'(round_up_o);
  assign round_carry_o = rsum[SIG_W];
  assign frac_o        = round_carry_o ? rsum[FRAC_W:1] : rsum[FRAC_W-1:0];
  assign exp_o         = exp_combine(exp_a_i, exp_b_i, norm_shift_o, round_carry_o);

  // R9: a carry out of rounding can only come from an all-ones kept field
  always_comb begin
    if (round_carry_o) begin
      assert_renorm_R9: assert (frac_o == '0 && round_up_o);
    end
  end
endmodule

// File: rtl/fp32_mul_pack.sv
module fp32_mul_pack
  import fp32_mul_pkg::*;
(
  input  num_class_e        cls_a_i,
  input  num_class_e        cls_b_i,
  input  logic              sign_i,
  input  logic [XEXP_W-1:0] exp_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic [WORD_W-1:0] word_o,
  output logic              ovf_o,
  output logic              unf_o,
  output logic              inv_o
);
  logic any_nan, any_inf, any_zero;
  logic exp_high, exp_low;

  assign any_nan  = (cls_a_i == CLS_NAN)  || (cls_b_i == CLS_NAN);
  assign any_inf  = (cls_a_i == CLS_INF)  || (cls_b_i == CLS_INF);
  assign any_zero = (cls_a_i == CLS_ZERO) || (cls_b_i == CLS_ZERO);
  assign exp_high = $signed(exp_i) > $signed(XEXP_W'(EXP_MAX));
  assign exp_low  = $signed(exp_i) < $signed(XEXP_W'(1));

  always_comb begin
    ovf_o = 1'b0;
    unf_o = 1'b0;
    inv_o = 1'b0;
    if (any_nan || (any_inf && any_zero)) begin
      word_o = qnan_word();
      inv_o  = 1'b1;
    end else if (any_inf) begin
      word_o = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (any_zero) begin
      word_o = {sign_i, {(WORD_W-1){1'b0}}};
    end else if (exp_high) begin
      word_o = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      ovf_o  = 1'b1;
    end else if (exp_low) begin
      word_o = {sign_i, {(WORD_W-1){1'b0}}};
      unf_o  = 1'b1;
    end else begin
      word_o = {sign_i, exp_i[EXP_W-1:0], frac_i};
    end
  end
endmodule

// File: rtl/fp32_mul.sv
module fp32_mul
  import fp32_mul_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  output logic [WORD_W-1:0] product,
  output logic              overflow,
  output logic              underflow,
  output logic              invalid
);
  localparam int N_OPS = 2;

  logic [WORD_W-1:0] ops      [N_OPS];
  logic              op_sign  [N_OPS];
  logic [EXP_W-1:0]  op_exp   [N_OPS];
  logic [SIG_W-1:0]  op_sig   [N_OPS];
  num_class_e        op_cls   [N_OPS];

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar i = 0; i < N_OPS; i++) begin : g_unpack
    fp32_mul_unpack u_unpack (
      .word_i (ops[i]),
      .sign_o (op_sign[i]),
      .exp_o  (op_exp[i]),
      .sig_o  (op_sig[i]),
      .cls_o  (op_cls[i])
    );
  end

  logic [FRAC_W-1:0] core_frac;
  logic [XEXP_W-1:0] core_exp;
  logic              ev_norm_shift;
  logic              ev_round_up;
  logic              ev_round_carry;

  fp32_mul_core u_core (
    .sig_a_i       (op_sig[0]),
    .sig_b_i       (op_sig[1]),
    .exp_a_i       (op_exp[0]),
    .exp_b_i       (op_exp[1]),
    .frac_o        (core_frac),
    .exp_o         (core_exp),
    .norm_shift_o  (ev_norm_shift),
    .round_up_o    (ev_round_up),
    .round_carry_o (ev_round_carry)
  );

  logic              res_sign;
  logic [WORD_W-1:0] res_word;
  logic              res_ovf, res_unf, res_inv;

  assign res_sign = op_sign[0] ^ op_sign[1];

  fp32_mul_pack u_pack (
    .cls_a_i (op_cls[0]),
    .cls_b_i (op_cls[1]),
    .sign_i  (res_sign),
    .exp_i   (core_exp),
    .frac_i  (core_frac),
    .word_o  (res_word),
    .ovf_o   (res_ovf),
    .unf_o   (res_unf),
    .inv_o   (res_inv)
  );

  logic seen_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      product   <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
      invalid   <= 1'b0;
      seen_edge <= 1'b0;
    end else begin
      product   <= res_word;
      overflow  <= res_ovf;
      underflow <= res_unf;
      invalid   <= res_inv;
      seen_edge <= 1'b1;
    end
  end

  assert_invalid_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |-> product == qnan_word());

  assert_overflow_inf_R3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (product[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));

  assert_underflow_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> (product[WORD_W-2:0] == '0));

  assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({overflow, underflow, invalid}));

  assert_sign_xor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_edge && !invalid) |-> product[WORD_W-1] == $past(op_a[WORD_W-1] ^ op_b[WORD_W-1]));

  assert_normal_inputs_no_inv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_cls[0] == CLS_NORM && op_cls[1] == CLS_NORM) |=> !invalid);
endmodule

// File: tb/fp32_mul_tb_top.sv
module fp32_mul_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 24;

  // fields: a, b, expected word, {ovf, unf, inv}, requirement number
  localparam logic [102:0] VEC [NVEC] = '{
    {32'h40000000, 32'h40400000, 32'h40C00000, 3'b000, 4'd1},  // R1 2*3
    {32'hBFC00000, 32'h40000000, 32'hC0400000, 3'b000, 4'd2},  // R2 -1.5*2
    {32'hBF400000, 32'hBF400000, 32'h3F100000, 3'b000, 4'd2},  // R2 neg*neg
    {32'h3FC00000, 32'h3FC00000, 32'h40100000, 3'b000, 4'd7},  // R7 1.5*1.5
    {32'h7F000000, 32'h40000000, 32'h7F800000, 3'b100, 4'd3},  // R3
    {32'hFF000000, 32'h40000000, 32'hFF800000, 3'b100, 4'd3},  // R3 neg
    {32'h7F7FFFFF, 32'h3F800001, 32'h7F800000, 3'b100, 4'd3},  // R3 via normalize
    {32'h00800000, 32'h3F000000, 32'h00000000, 3'b010, 4'd4},  // R4
    {32'h80800000, 32'h3F000000, 32'h80000000, 3'b010, 4'd4},  // R4 neg
    {32'h00800000, 32'h3F800000, 32'h00800000, 3'b000, 4'd4},  // R4 edge min
    {32'h7F000000, 32'h3F800000, 32'h7F000000, 3'b000, 4'd3},  // R3 edge max
    {32'h3F800001, 32'h3FC00000, 32'h3FC00002, 3'b000, 4'd8},  // R8 tie up
    {32'h3F800003, 32'h3FC00000, 32'h3FC00004, 3'b000, 4'd8},  // R8 tie down
    {32'h3F800001, 32'h3FC00001, 32'h3FC00003, 3'b000, 4'd8},  // R8 sticky
    {32'h3F800001, 32'h3F800001, 32'h3F800002, 3'b000, 4'd8},  // R8 below half
    {32'h3F842108, 32'h3FF80000, 32'h40000000, 3'b000, 4'd9},  // R9 carry
    {32'h00000000, 32'h7F800000, 32'h7FC00000, 3'b001, 4'd5},  // R5 0*inf
    {32'h7FC00001, 32'h3F800000, 32'h7FC00000, 3'b001, 4'd5},  // R5 nan
    {32'h3F800000, 32'hFF800001, 32'h7FC00000, 3'b001, 4'd5},  // R5 nan b
    {32'h7F800000, 32'h40000000, 32'h7F800000, 3'b000, 4'd6},  // R6 inf
    {32'hFF800000, 32'h40000000, 32'hFF800000, 3'b000, 4'd6},  // R6 -inf
    {32'h80000000, 32'h40A00000, 32'h80000000, 3'b000, 4'd6},  // R6 -0
    {32'h00000001, 32'h40000000, 32'h00000000, 3'b000, 4'd6},  // R6 subnormal
    {32'h00400000, 32'h7F800000, 32'h7FC00000, 3'b001, 4'd6}   // R6 subnormal*inf
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [31:0] product;
  logic        overflow, underflow, invalid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp32_mul dut_i (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
    .product(product), .overflow(overflow), .underflow(underflow), .invalid(invalid)
  );

  task automatic check(input string req, input logic [31:0] exp_w, input logic [2:0] exp_f);
    checks++;
    if (product !== exp_w || {overflow, underflow, invalid} !== exp_f) begin
      errors++;
      $display("FAIL %s: actual %h flags %b, expected %h flags %b",
               req, product, {overflow, underflow, invalid}, exp_w, exp_f);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op_a = a;
    op_b = b;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset", 32'h0, 3'b000);
    op_a = 32'h40000000;
    op_b = 32'h40400000;
    @(negedge clk);
    check("R10 held in reset", 32'h0, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 first result", 32'h40C00000, 3'b000);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][102:71], VEC[i][70:39]);
      check($sformatf("R%0d vector %0d", VEC[i][3:0], i), VEC[i][38:7], VEC[i][6:4]);
    end

    // R10: output changes only at the clock edge after new operands
    @(negedge clk);
    op_a = 32'h40000000;
    op_b = 32'h3F800000;
    #(CLK_PERIOD/4);
    check("R10 before edge", 32'h7FC00000, 3'b001);
    @(negedge clk);
    check("R10 after edge", 32'h40000000, 3'b000);

    // R1: exponent arithmetic on a wider spread of magnitudes
    apply(32'h3E800000, 32'h42000000);  // 0.25 * 32 = 8
    check("R1 scaled", 32'h41000000, 3'b000);

    // R10: asynchronous reset clears a set flag
    apply(32'h7F000000, 32'h7F000000);
    check("R3 large", 32'h7F800000, 3'b100);
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    check("R10 async clear", 32'h0, 3'b000);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout, expected completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule